// File: doc/BRIEF.md
# Delayed-Interrupt UART Register Front End

This block is the host-facing register set of a classic eight-offset, byte-wide UART. A host bus reads and writes the registers one byte at a time. Received characters come from a byte source through a valid/ready pair. Transmitted characters go out to a byte sink on a valid strobe. Line timing, baud generation, FIFOs and modem pins live elsewhere. Divisor-latch accesses are accepted and discarded.

Interrupts are not posted the moment their cause appears. Each of the two causes, receive data and transmit-holding-empty, owns a countdown of `DELAY_CYC` clock cycles. Every re-arm restarts that countdown from its full length. The pending bit is set only when the countdown expires. The exceptions are a fresh byte arrival, which raises receive pending at once, and a transmit enable that comes more than the delay after the previous transmit interrupt, which also raises transmit pending at once. The single `irq_o` line is the OR of both pending bits, each gated by its enable.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the enable (offset 1), line-control (offset 3) and modem-control (offset 4) registers read 0x00. The identification register (offset 2) reads 0x01, and `irq_o` is low.
- R2: While line-control bit 7 is set, reads of offsets 0 and 1 return 0x00 and writes to offsets 0 and 1 change nothing: no byte reaches the sink and the enable register keeps its value.
- R3: A read of offset 0 returns `rx_data_i` and pulses `rx_ready_o` when `rx_valid_i` is high, and returns 0x00 otherwise. The read always clears receive pending.
- R4: Offset 5 reads 0x60, with bit 0 also set while `rx_valid_i` is high. Offsets 6 and 7 read 0x00. Writes to offsets 2 and 7 have no effect.
- R5: A write of offset 0 presents the byte on `tx_data_o` with `tx_valid_o` high in the same cycle and clears transmit pending. If enable bit 1 is set, the write arms the transmit countdown.
- R6: A write of offset 1 with bit 1 set raises transmit pending at once if more than `DELAY_CYC` cycles have passed since the last transmit interrupt, and otherwise arms the transmit countdown. A write with bit 1 clear cancels the countdown and clears transmit pending.
- R7: A write of offset 1 with bit 0 set while `rx_valid_i` is high arms the receive countdown. Any other write of offset 1 cancels that countdown and clears receive pending. A data read after which `rx_valid_i` is still high on the next cycle, with bit 0 set, arms the receive countdown.
- R8: A read of offset 2 returns 0x04 when receive is pending, otherwise 0x02 when transmit is pending, otherwise 0x01. Only a read that returns 0x02 clears transmit pending.
- R9: An armed countdown sets its pending bit exactly `DELAY_CYC` clock edges after the arming edge. Re-arming a running countdown restarts the full delay.
- R10: A rising edge of `rx_valid_i` while enable bit 0 is set raises receive pending on that clock edge.
- R11: The modem-control register becomes 0x9A only on a write of exactly 0x1A, where bit 4 is the loopback bit. Every other write leaves it unchanged.
- R12: `irq_o` is high whenever receive pending (with enable bit 0) or transmit pending (with enable bit 1) is set. It therefore stays high after a data read while transmit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access strobe, one byte per cycle |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of a read access |
| rx_valid_i | input | 1 | Source holds a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Byte taken by a data read |
| tx_valid_o | output | 1 | Byte presented to the sink |
| tx_data_o | output | 8 | Byte to transmit |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never reads offset 0 in the same cycle that `rx_valid_i` rises. They also assume that a countdown is never re-armed by a host write on the very edge it expires. When either collision does happen, the design resolves it by a fixed priority that the checks do not describe. The bench keeps clear of both cases. It changes the source's valid and data only between host accesses, and it leaves at least a full delay, plus margin, between an arming write and any later access that could collide with the expiry. The sweep covers all 256 modem-control write values in both register states, and it checks every countdown at the edge just before expiry and at the expiry edge itself.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  typedef enum logic [2:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IID  = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LSTS = 3'd5,
    OFS_MSTS = 3'd6,
    OFS_SCR  = 3'd7
  } reg_ofs_e;

  localparam int unsigned IEN_RX_BIT  = 0;
  localparam int unsigned IEN_TX_BIT  = 1;
  localparam int unsigned LCTL_DL_BIT = 7;

  localparam logic [7:0] IID_RX   = 8'h04;
  localparam logic [7:0] IID_TX   = 8'h02;
  localparam logic [7:0] IID_NONE = 8'h01;

  localparam logic [7:0] LSTS_IDLE = 8'h60;
  localparam logic [7:0] LSTS_DR   = 8'h01;

  localparam logic [7:0] MCTL_LOOP  = 8'h10;
  localparam logic [7:0] MCTL_KEY   = MCTL_LOOP | 8'h0A;
  localparam logic [7:0] MCTL_LATCH = 8'h9A;

  localparam int unsigned N_SRC  = 2;
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_TX = 1;
endpackage

// File: rtl/uart_delay_timer.sv
module uart_delay_timer #(
  parameter int unsigned DELAY_CYC = 56
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (arm_i)         cnt_q <= LOAD;
    else if (cancel_i)      cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // restart wins over expiry in the same cycle
  assign fire_o = (cnt_q == CW'(1)) && !arm_i && !cancel_i;

  // R9
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cnt_q == LOAD));

  // R9
  fire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/uart_irq_age.sv
module uart_irq_age #(
  parameter int unsigned LIMIT = 56
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic old_o
);
  localparam int unsigned AW = $clog2(LIMIT + 2);
  localparam logic [AW-1:0] SAT = AW'(LIMIT + 1);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (clr_i)       age_q <= '0;
    else if (age_q != SAT) age_q <= age_q + 1'b1;
  end

  assign old_o = (age_q == SAT);

  // R6
  age_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q <= SAT));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 56
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_ready_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);
  logic [7:0] ien_q, lctl_q, mctl_q;
  logic       rx_pend_q, tx_pend_q;
  logic       rx_valid_q, pop_q;

  logic dl_mode, acc_rd, acc_wr;
  logic rd_data, wr_data, wr_ien, rd_iid, wr_lctl, wr_mctl;
  logic ien_rx, ien_tx, new_rx_en, new_tx_en;
  logic rx_rise, tx_old, tx_now;
  logic rx_set, rx_clr, tx_set, tx_clr;
  logic [N_SRC-1:0] t_arm, t_cancel, t_fire;

  assign dl_mode = lctl_q[LCTL_DL_BIT];
  assign acc_rd  = req_i && !we_i;
  assign acc_wr  = req_i && we_i;
  assign rd_data = acc_rd && (addr_i == OFS_DATA) && !dl_mode;
  assign wr_data = acc_wr && (addr_i == OFS_DATA) && !dl_mode;
  assign wr_ien  = acc_wr && (addr_i == OFS_IEN) && !dl_mode;
  assign rd_iid  = acc_rd && (addr_i == OFS_IID);
  assign wr_lctl = acc_wr && (addr_i == OFS_LCTL);
  assign wr_mctl = acc_wr && (addr_i == OFS_MCTL) && (wdata_i == MCTL_KEY);

  assign ien_rx    = ien_q[IEN_RX_BIT];
  assign ien_tx    = ien_q[IEN_TX_BIT];
  assign new_rx_en = wdata_i[IEN_RX_BIT];
  assign new_tx_en = wdata_i[IEN_TX_BIT];
  assign rx_rise   = rx_valid_i && !rx_valid_q;

  assign rx_ready_o = rd_data && rx_valid_i;
  assign tx_valid_o = wr_data;
  assign tx_data_o  = wdata_i;

  // countdown controls
  assign t_arm[SRC_RX]    = (pop_q && rx_valid_i && ien_rx) ||
                            (wr_ien && new_rx_en && rx_valid_i);
  assign t_cancel[SRC_RX] = wr_ien && !(new_rx_en && rx_valid_i);
  assign t_arm[SRC_TX]    = (wr_data && ien_tx) || (wr_ien && new_tx_en && !tx_old);
  assign t_cancel[SRC_TX] = wr_ien && !new_tx_en;
  assign tx_now           = wr_ien && new_tx_en && tx_old;

  for (genvar g = 0; g < N_SRC; g++) begin : g_tmr
    uart_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (t_arm[g]),
      .cancel_i (t_cancel[g]),
      .fire_o   (t_fire[g])
    );
  end

  uart_irq_age #(.LIMIT(DELAY_CYC)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tx_set),
    .old_o  (tx_old)
  );

  assign rx_set = (t_fire[SRC_RX] || rx_rise) && ien_rx;
  assign rx_clr = rd_data || t_cancel[SRC_RX];
  assign tx_set = (t_fire[SRC_TX] && ien_tx) || tx_now;
  assign tx_clr = wr_data || t_cancel[SRC_TX] || (rd_iid && !rx_pend_q && tx_pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q      <= '0;
      lctl_q     <= '0;
      mctl_q     <= '0;
      rx_pend_q  <= 1'b0;
      tx_pend_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      pop_q      <= 1'b0;
    end else begin
      rx_valid_q <= rx_valid_i;
      pop_q      <= rd_data;
      if (wr_ien)  ien_q  <= wdata_i;
      if (wr_lctl) lctl_q <= wdata_i;
      if (wr_mctl) mctl_q <= MCTL_LATCH;
      if (rx_clr)      rx_pend_q <= 1'b0;
      else if (rx_set) rx_pend_q <= 1'b1;
      if (tx_set)      tx_pend_q <= 1'b1;
      else if (tx_clr) tx_pend_q <= 1'b0;
    end
  end

  assign irq_o = (rx_pend_q && ien_rx) || (tx_pend_q && ien_tx);

  always_comb begin
    rdata_o = '0;
    if (acc_rd) begin
      unique case (addr_i)
        OFS_DATA: rdata_o = (!dl_mode && rx_valid_i) ? rx_data_i : 8'h00;
        OFS_IEN:  rdata_o = dl_mode ? 8'h00 : ien_q;
        OFS_IID:  rdata_o = rx_pend_q ? IID_RX : (tx_pend_q ? IID_TX : IID_NONE);
        OFS_LCTL: rdata_o = lctl_q;
        OFS_MCTL: rdata_o = mctl_q;
        OFS_LSTS: rdata_o = LSTS_IDLE | (rx_valid_i ? LSTS_DR : 8'h00);
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  // R3
  data_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 3'd0 && !lctl_q[7]) |=> !rx_pend_q);

  // R5
  data_write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_pend_q);

  // R10
  arrival_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_valid_i) && ien_q[0] && !req_i) |=> irq_o);

  // R11
  mctl_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mctl_q) |-> $past(req_i && we_i && addr_i == 3'd4 && wdata_i == 8'h1A));

  // R2
  dl_ien_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 3'd1 && lctl_q[7]) |=> $stable(ien_q));

  // R6
  tx_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_pend_q) |-> $past(t_fire[SRC_TX] || (req_i && we_i && addr_i == 3'd1)));

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> rx_valid_i);
endmodule

// File: tb/uart_reg_front_bench.sv
module uart_reg_front_bench;
  localparam int unsigned D = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid;
  logic [7:0] tx_data;
  logic       irq;

  int checks = 0;
  int fails = 0;
  logic [7:0] rv;
  logic       rr, tv;
  logic [7:0] td;

  always #2 clk = ~clk;

  uart_reg_front #(.DELAY_CYC(D)) u_uart_reg_front (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 tv = tx_valid; td = tx_data;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    req = 1'b1; we = 1'b0; addr = a;
    #1 rv = rdata; rr = rx_ready;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(3'd1); chk("R1 ien", rv, 8'h00);
    rd(3'd3); chk("R1 lctl", rv, 8'h00);
    rd(3'd4); chk("R1 mctl", rv, 8'h00);
    rd(3'd2); chk("R1 iid", rv, 8'h01);

    // R11 modem-control key sweep
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h1A) begin
        wr(3'd4, 8'(v)); rd(3'd4); chk("R11 no latch", rv, 8'h00);
      end
    end
    wr(3'd4, 8'h1A); rd(3'd4); chk("R11 latch", rv, 8'h9A);
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, 8'(v)); rd(3'd4); chk("R11 hold", rv, 8'h9A);
    end

    // R4 status, modem status, scratch, FIFO-control writes
    rd(3'd5); chk("R4 lsts empty", rv, 8'h60);
    rd(3'd6); chk("R4 msts", rv, 8'h00);
    wr(3'd7, 8'h55); rd(3'd7); chk("R4 scratch", rv, 8'h00);
    wr(3'd2, 8'hFF); rd(3'd2); chk("R4 fcr iid", rv, 8'h01);
    rd(3'd1); chk("R4 fcr ien", rv, 8'h00);

    // R2 divisor-latch mode
    wr(3'd3, 8'h80);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h55); chk("R2 no tx", tv, 0);
    rd(3'd0); chk("R2 rd0", rv, 8'h00);
    rd(3'd1); chk("R2 rd1", rv, 8'h00);
    rd(3'd3); chk("R2 lctl", rv, 8'h80);
    wr(3'd3, 8'h03);
    rd(3'd1); chk("R2 ien kept", rv, 8'h00);
    chk("R2 irq", irq, 0);

    // R6 immediate transmit interrupt (long since reset)
    wr(3'd1, 8'h02); chk("R6 immediate irq R12", irq, 1);
    rd(3'd2); chk("R8 tx code", rv, 8'h02);
    chk("R8 tx cleared", irq, 0);
    rd(3'd2); chk("R8 none", rv, 8'h01);
    // R6 delayed: recent transmit interrupt
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h02);
    edges(D - 1); chk("R6 delayed early", irq, 0);
    edges(1);     chk("R6 delayed fire", irq, 1);
    wr(3'd1, 8'h00); chk("R6 disable clears", irq, 0);
    rd(3'd2); chk("R6 iid none", rv, 8'h01);

    // R5 and R9 data write, restart
    edges(2 * D + 2);
    wr(3'd1, 8'h02); chk("R6 immediate again", irq, 1);
    wr(3'd0, 8'h41);
    chk("R5 valid", tv, 1); chk("R5 data", td, 8'h41); chk("R5 clears", irq, 0);
    edges(3);
    wr(3'd0, 8'h42); chk("R5 data2", td, 8'h42);
    edges(D - 1); chk("R9 restart early", irq, 0);
    edges(1);     chk("R9 restart fire", irq, 1);
    rd(3'd2); chk("R8 tx code2", rv, 8'h02);
    wr(3'd1, 8'h00);

    // R10 arrival and R3/R7 follow-on data
    wr(3'd1, 8'h01); chk("R7 no data no irq", irq, 0);
    rx_valid = 1'b1; rx_data = 8'hA5;
    edges(1); chk("R10 arrival irq", irq, 1);
    rd(3'd0); chk("R3 data", rv, 8'hA5); chk("R3 ready", rr, 1);
    rx_data = 8'h3C;
    chk("R3 clears", irq, 0);
    edges(D); chk("R7 pop early", irq, 0);
    edges(1); chk("R7 pop fire", irq, 1);

    // R8 priority with both pending
    wr(3'd1, 8'h03);
    edges(D + 1);
    rd(3'd2); chk("R8 rx first", rv, 8'h04);
    rd(3'd2); chk("R8 tx kept", rv, 8'h04);
    rd(3'd5); chk("R4 lsts ready", rv, 8'h61);
    rd(3'd0); chk("R3 data2", rv, 8'h3C);
    rx_valid = 1'b0;
    chk("R12 irq holds on tx", irq, 1);
    rd(3'd2); chk("R8 then tx", rv, 8'h02);
    rd(3'd2); chk("R8 then none", rv, 8'h01);
    rd(3'd0); chk("R3 empty", rv, 8'h00); chk("R3 empty ready", rr, 0);

    // R7 cancel paths
    rx_valid = 1'b1; rx_data = 8'h77;
    edges(1); chk("R10 arrival2", irq, 1);
    wr(3'd1, 8'h02);
    rd(3'd2); chk("R7 rx cleared", rv, 8'h02);
    rd(3'd2); chk("R7 then none", rv, 8'h01);
    wr(3'd1, 8'h01);
    edges(3);
    wr(3'd1, 8'h00);
    edges(D + 2); chk("R7 cancel irq", irq, 0);
    rd(3'd2); chk("R7 cancel iid", rv, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule